// File: doc/BRIEF.md
# ADC Sample Sequencer FIFO Bank

This block holds the converted samples of an analog-to-digital converter in four independent sample FIFOs, one per sample sequencer, each sixteen words deep. A single-cycle trigger pulse, typically from a timer, writes the value present on the sample input into the FIFO of sequencer 0, provided that sequencer is enabled. It also raises that sequencer's raw interrupt bit. Software pops samples through a per-sequencer read register. A packed status word per sequencer shows the raw read and write pointers and the empty and full flags.

Errors are kept, not hidden. A push into a full FIFO is discarded and marks an overflow bit. A pop from an empty FIFO marks an underflow bit, moves no pointer and returns whatever word sits at the read pointer. The interrupt, overflow and underflow bits are sticky and are cleared by writing ones. The interrupt line is the OR of the raw interrupt bits that are unmasked. The conversion itself and any arbitration between sequencers live outside this block.

The bus is a plain strobe interface. Read data is combinational in the cycle of `bus_rd`, and the pop takes effect at the closing edge of that cycle.

Top module: `adc_seq_fifo_bank`

## Requirements
- R1: After reset every FIFO status word reads 0x100 (empty, both pointers 0), all global registers read 0 and `irq` is low.
- R2: A trigger while bit 0 of the enable register (offset 0x00, 4 bits kept) is 0 leaves FIFO 0 status and the raw interrupt register (0x04) unchanged.
- R3: With sequencer 0 enabled, a trigger stores the `sample` value present at that clock edge into FIFO 0 and sets raw interrupt bit 0. Reads of the FIFO register (0x48) return samples in arrival order, zero-extended to 32 bits.
- R4: The status word of sequencer n (0x4C + n*0x20) has the read pointer in bits 3:0, the write pointer in bits 7:4, empty at bit 8 and full at bit 12, with all other bits 0.
- R5: A push into a full FIFO without a same-cycle pop is discarded: the contents and pointers are unchanged, and overflow bit n (register 0x10) is set.
- R6: A read of the FIFO register of an empty sequencer n returns the entry at the read pointer, leaves both pointers unchanged and sets underflow bit n (register 0x18).
- R7: The interrupt clear register (0x0C), overflow (0x10) and underflow (0x18) registers clear the bits written as 1. A set event in the same cycle as a clear wins.
- R8: `irq` is high exactly when raw status AND mask (0x08, 4 bits) is nonzero. A read of 0x0C returns raw AND mask.
- R9: Sample mux writes (0x40 + n*0x20) keep only bits 0x33333333. Control writes (0x44 + n*0x20) keep bits 3:0. The trigger select register (0x14) keeps all 32 bits.
- R10: A pop and a push in the same cycle are both performed. On a full FIFO it stays full with no overflow. On an empty FIFO the pop underflows and returns the stale entry, and the push is stored.
- R11: Both pointers wrap from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on FIFO register) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| trig | input | 1 | Conversion-done trigger pulse |
| sample | input | 10 | Sample value captured on a trigger edge |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a trigger push into FIFO 0 and a software pop from it. The bench provokes this once on a full FIFO and once on an empty one. It judges the read data, the status word and the overflow and underflow bits afterwards. The second pair is a sticky set event and a write-one-to-clear of the same bit. It is provoked by writing the interrupt clear register in the cycle of an accepted trigger, and the raw bit must read back as 1. A behavioural queue model runs beside the design, and `irq` is compared with the model on every clock.

// File: rtl/adc_fifo_pkg.sv
// Package: shared constants of the sample FIFO bank (register offsets,
// field positions of the status word, write masks).
package adc_fifo_pkg;
    localparam logic [7:0]  A_ENABLE   = 8'h00;
    localparam logic [7:0]  A_RAW      = 8'h04;
    localparam logic [7:0]  A_MASK     = 8'h08;
    localparam logic [7:0]  A_ISC      = 8'h0C;
    localparam logic [7:0]  A_OVF      = 8'h10;
    localparam logic [7:0]  A_TSEL     = 8'h14;
    localparam logic [7:0]  A_UNF      = 8'h18;
    localparam logic [7:0]  A_SEQ_BASE = 8'h40;
    localparam int          SEQ_STRIDE = 32;
    localparam logic [4:0]  O_MUX      = 5'h00;
    localparam logic [4:0]  O_CTL      = 5'h04;
    localparam logic [4:0]  O_FIFO     = 5'h08;
    localparam logic [4:0]  O_STAT     = 5'h0C;
    localparam logic [31:0] MUX_KEEP   = 32'h3333_3333;
    localparam int          ST_HEAD_LSB = 4;
    localparam int          ST_EMPTY    = 8;
    localparam int          ST_FULL     = 12;
endpackage

// File: rtl/adc_sample_fifo.sv
// Module: one sample FIFO with raw pointers and registered empty/full flags.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
// A pop of an empty FIFO moves nothing; a push into a full FIFO is dropped
// unless a pop happens in the same cycle. dout always shows the entry at tail.
module adc_sample_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 10,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             empty,
    output logic             full,
    output logic             ovf_evt,
    output logic             unf_evt
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_push, do_pop;
    logic [PTR_W-1:0] head_nx, tail_nx;

    // Which operations actually take effect this cycle.
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || pop);
    assign head_nx = head + PTR_W'(1);
    assign tail_nx = tail + PTR_W'(1);
    assign dout    = mem[tail];
    assign ovf_evt = push && full && !pop;
    assign unf_evt = pop && empty;

    // Storage, pointers and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            head  <= '0;
            tail  <= '0;
            empty <= 1'b1;
            full  <= 1'b0;
        end else begin
            if (do_push) begin
                mem[head] <= din;
                head      <= head_nx;
            end
            if (do_pop) tail <= tail_nx;
            if (do_push && !do_pop) begin
                empty <= 1'b0;
                full  <= (head_nx == tail);
            end else if (do_pop && !do_push) begin
                full  <= 1'b0;
                empty <= (tail_nx == head);
            end
        end
    end

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    p_full_ptrs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full || empty) |-> (head == tail));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ($stable(head) && full));
    p_underflow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> ($stable(tail) && empty));
    p_simul_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full) |=> full);
endmodule

// File: rtl/adc_sticky_w1c.sv
// Module: a vector of sticky status bits, cleared by writing ones.
// Assumes set and clr are single-cycle qualified; a set beats a clear.
module adc_sticky_w1c #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // Hold, clear on write-one, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set;
    end

    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set == '0 && clr == '0) |=> $stable(q));
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/adc_seq_fifo_bank.sv
// Module: register front end of the sample FIFO bank. Decodes the strobe bus,
// routes triggers to FIFO 0, keeps the sticky interrupt/overflow/underflow bits
// and drives the interrupt line. Assumes NUM_SEQ*SEQ_STRIDE fits in 8 address
// bits above the sequencer base and FIFO_DEPTH <= 16 (status field widths).
module adc_seq_fifo_bank
    import adc_fifo_pkg::*;
#(
    parameter int NUM_SEQ    = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int SAMPLE_W   = 10,
    parameter int CTL_W      = 4,
    localparam int PTR_W     = $clog2(FIFO_DEPTH),
    localparam int IDX_W     = $clog2(NUM_SEQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                trig,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                irq
);
    logic [7:0]         seq_rel;
    logic               in_seq;
    logic [IDX_W-1:0]   seq_idx;
    logic [4:0]         reg_off;
    logic [NUM_SEQ-1:0] en_q, im_q, ris_q, ovf_q, unf_q;
    logic [NUM_SEQ-1:0] push_v, pop_v, ovf_v, unf_v;
    logic [NUM_SEQ-1:0] ris_clr, ovf_clr, unf_clr;
    logic [31:0]        tsel_q;
    logic [31:0]        mux_q [NUM_SEQ];
    logic [CTL_W-1:0]   ctl_q [NUM_SEQ];
    logic [SAMPLE_W-1:0] f_dout [NUM_SEQ];
    logic [PTR_W-1:0]   f_head [NUM_SEQ];
    logic [PTR_W-1:0]   f_tail [NUM_SEQ];
    logic [NUM_SEQ-1:0] f_empty, f_full;

    // Address decode into the per-sequencer window.
    assign seq_rel = bus_addr - A_SEQ_BASE;
    assign in_seq  = seq_rel < 8'(NUM_SEQ * SEQ_STRIDE);
    assign seq_idx = seq_rel[5 +: IDX_W];
    assign reg_off = seq_rel[4:0];

    // One FIFO per sequencer; only sequencer 0 is fed by the trigger.
    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        assign pop_v[g] = bus_rd && in_seq && (seq_idx == IDX_W'(g)) && (reg_off == O_FIFO);
        if (g == 0) begin : g_fed
            assign push_v[g] = trig && en_q[0];
        end else begin : g_idle
            assign push_v[g] = 1'b0;
        end
        adc_sample_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SAMPLE_W)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push_v[g]), .pop(pop_v[g]),
            .din(sample), .dout(f_dout[g]), .head(f_head[g]), .tail(f_tail[g]),
            .empty(f_empty[g]), .full(f_full[g]),
            .ovf_evt(ovf_v[g]), .unf_evt(unf_v[g]));

        // Per-sequencer configuration registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mux_q[g] <= '0;
                ctl_q[g] <= '0;
            end else if (bus_wr && in_seq && seq_idx == IDX_W'(g)) begin
                if (reg_off == O_MUX) mux_q[g] <= bus_wdata & MUX_KEEP;
                if (reg_off == O_CTL) ctl_q[g] <= bus_wdata[CTL_W-1:0];
            end
        end
    end

    // Plain global registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            im_q   <= '0;
            tsel_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_ENABLE) en_q   <= bus_wdata[NUM_SEQ-1:0];
            if (bus_addr == A_MASK)   im_q   <= bus_wdata[NUM_SEQ-1:0];
            if (bus_addr == A_TSEL)   tsel_q <= bus_wdata;
        end
    end

    // Write-one-to-clear requests.
    assign ris_clr = (bus_wr && bus_addr == A_ISC) ? bus_wdata[NUM_SEQ-1:0] : '0;
    assign ovf_clr = (bus_wr && bus_addr == A_OVF) ? bus_wdata[NUM_SEQ-1:0] : '0;
    assign unf_clr = (bus_wr && bus_addr == A_UNF) ? bus_wdata[NUM_SEQ-1:0] : '0;

    adc_sticky_w1c #(.W(NUM_SEQ)) u_ris (.clk(clk), .rst_n(rst_n), .set(push_v), .clr(ris_clr), .q(ris_q));
    adc_sticky_w1c #(.W(NUM_SEQ)) u_ovf (.clk(clk), .rst_n(rst_n), .set(ovf_v),  .clr(ovf_clr), .q(ovf_q));
    adc_sticky_w1c #(.W(NUM_SEQ)) u_unf (.clk(clk), .rst_n(rst_n), .set(unf_v),  .clr(unf_clr), .q(unf_q));

    assign irq = |(ris_q & im_q);

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (in_seq) begin
            unique case (reg_off)
                O_MUX:  bus_rdata = mux_q[seq_idx];
                O_CTL:  bus_rdata = 32'(ctl_q[seq_idx]);
                O_FIFO: bus_rdata = 32'(f_dout[seq_idx]);
                O_STAT: begin
                    bus_rdata[PTR_W-1:0]               = f_tail[seq_idx];
                    bus_rdata[ST_HEAD_LSB +: PTR_W]    = f_head[seq_idx];
                    bus_rdata[ST_EMPTY]                = f_empty[seq_idx];
                    bus_rdata[ST_FULL]                 = f_full[seq_idx];
                end
                default: bus_rdata = '0;
            endcase
        end else begin
            unique case (bus_addr)
                A_ENABLE: bus_rdata = 32'(en_q);
                A_RAW:    bus_rdata = 32'(ris_q);
                A_MASK:   bus_rdata = 32'(im_q);
                A_ISC:    bus_rdata = 32'(ris_q & im_q);
                A_OVF:    bus_rdata = 32'(ovf_q);
                A_TSEL:   bus_rdata = tsel_q;
                A_UNF:    bus_rdata = 32'(unf_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_trig_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !en_q[0] && !bus_rd) |=> ($stable(f_head[0]) && $stable(f_empty[0])));
    p_trig_sets_ris_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && en_q[0]) |=> ris_q[0]);
    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (im_q == '0) |-> !irq);
endmodule

// File: tb/tb_adc_seq_fifo_bank.sv
// Bench: behavioural queue model of the FIFO bank, compared at every
// falling edge (irq) and on every register read.
module tb_adc_seq_fifo_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, trig = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  sample = '0;
    logic        irq;
    int          n_checks = 0, n_errors = 0;
    bit          running = 1'b0;

    // Reference model state.
    int          m_mem [4][16];
    int          m_hd [4], m_tl [4], m_cnt [4];
    int          m_en, m_im, m_ris, m_ovf, m_unf, m_tsel;
    int          m_mux [4], m_ctl [4];

    always #2.5 clk = ~clk;

    adc_seq_fifo_bank dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig(trig), .sample(sample), .irq(irq));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 16; i++) m_mem[s][i] = 0;
            m_hd[s] = 0; m_tl[s] = 0; m_cnt[s] = 0; m_mux[s] = 0; m_ctl[s] = 0;
        end
        m_en = 0; m_im = 0; m_ris = 0; m_ovf = 0; m_unf = 0; m_tsel = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int s;
        if (a >= 8'h40 && a < 8'hC0) begin
            s = (a - 8'h40) / 32;
            case (a % 32)
                0:  return m_mux[s];
                4:  return m_ctl[s];
                8:  return m_mem[s][m_tl[s]];
                12: return m_tl[s] | (m_hd[s] << 4) | ((m_cnt[s] == 0) << 8) | ((m_cnt[s] == 16) << 12);
                default: return 0;
            endcase
        end
        case (a)
            8'h00: return m_en;
            8'h04: return m_ris;
            8'h08: return m_im;
            8'h0C: return m_ris & m_im;
            8'h10: return m_ovf;
            8'h14: return m_tsel;
            8'h18: return m_unf;
            default: return 0;
        endcase
    endfunction

    // Advance the model by one clock edge given the cycle's stimulus.
    task automatic model_step(input bit wr, input bit rd, input logic [7:0] a,
                              input logic [31:0] wd, input bit tg, input logic [9:0] smp);
        int s;
        if (wr) begin
            if (a >= 8'h40 && a < 8'hC0) begin
                s = (a - 8'h40) / 32;
                if (a % 32 == 0) m_mux[s] = wd & 32'h3333_3333;
                if (a % 32 == 4) m_ctl[s] = wd & 32'hF;
            end
            case (a)
                8'h00: m_en = wd & 'hF;
                8'h08: m_im = wd & 'hF;
                8'h0C: m_ris = m_ris & ~wd;
                8'h10: m_ovf = m_ovf & ~wd & 'hF;
                8'h14: m_tsel = wd;
                8'h18: m_unf = m_unf & ~wd & 'hF;
                default: ;
            endcase
        end
        if (rd && a >= 8'h40 && a < 8'hC0 && a % 32 == 8) begin
            s = (a - 8'h40) / 32;
            if (m_cnt[s] > 0) begin m_tl[s] = (m_tl[s] + 1) % 16; m_cnt[s]--; end
            else m_unf |= (1 << s);
        end
        if (tg && (m_en & 1)) begin
            m_ris |= 1;
            if (m_cnt[0] < 16) begin
                m_mem[0][m_hd[0]] = smp;
                m_hd[0] = (m_hd[0] + 1) % 16;
                m_cnt[0]++;
            end else m_ovf |= 1;
        end
    endtask

    // One bus cycle: drive after the falling edge, judge read data, step model.
    task automatic cyc(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] wd,
                       input bit tg, input logic [9:0] smp, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; trig = tg; sample = smp;
        #1;
        if (rd) check(tag, bus_rdata, model_read(a));
        @(posedge clk);
        model_step(wr, rd, a, wd, tg, smp);
        #0.5;
        bus_wr = 0; bus_rd = 0; trig = 0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0, "write");
    endtask
    task automatic rd_reg(input logic [7:0] a, input string tag);
        cyc(0, 1, a, 0, 0, 0, tag);
    endtask
    task automatic rd_const(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask
    task automatic fire(input logic [9:0] smp);
        cyc(0, 0, 8'h00, 0, 1, smp, "trigger");
    endtask

    // irq compared with the model on every falling edge.
    always @(negedge clk) begin
        if (running) check("R8 irq", {31'b0, irq}, {31'b0, (m_ris & m_im) != 0});
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        running = 1'b1;
        // R1 reset state
        for (int s = 0; s < 4; s++) rd_const(8'h4C + 8'(s * 32), 32'h100, "R1 status");
        rd_const(8'h00, 0, "R1 enable");
        rd_const(8'h04, 0, "R1 raw");
        rd_const(8'h10, 0, "R1 ovf");
        rd_const(8'h18, 0, "R1 unf");
        check("R1 irq", {31'b0, irq}, 32'h0);
        // R2 trigger ignored when disabled
        fire(10'h123);
        rd_const(8'h4C, 32'h100, "R2 status");
        rd_const(8'h04, 0, "R2 raw");
        // R9 register masks
        wr_reg(8'h00, 32'hFF);
        rd_const(8'h00, 32'hF, "R9 enable");
        wr_reg(8'h80, 32'hFFFF_FFFF);
        rd_const(8'h80, 32'h3333_3333, "R9 mux");
        wr_reg(8'h64, 32'hFF);
        rd_const(8'h64, 32'hF, "R9 ctl");
        wr_reg(8'h14, 32'hDEAD_BEEF);
        rd_reg(8'h14, "R9 tsel");
        // R3 store and order, R8 mask
        wr_reg(8'h08, 32'h1);
        fire(10'h201); fire(10'h2A5); fire(10'h3FF);
        rd_const(8'h4C, 32'h030, "R4 status three");
        rd_const(8'h0C, 32'h1, "R8 isc");
        rd_const(8'h48, 32'h201, "R3 first");
        rd_reg(8'h48, "R3 pop1"); rd_reg(8'h48, "R3 pop2"); rd_reg(8'h48, "R3 pop3");
        rd_const(8'h4C, 32'h133, "R4 status drained");
        // R6 underflow on a never-written FIFO and on FIFO 0
        rd_reg(8'h68, "R6 seq1 read");
        rd_const(8'h18, 32'h2, "R6 unf seq1");
        rd_const(8'h6C, 32'h100, "R6 seq1 ptrs");
        rd_reg(8'h48, "R6 seq0 stale");
        rd_const(8'h4C, 32'h133, "R6 seq0 ptrs");
        rd_const(8'h18, 32'h3, "R6 unf both");
        // R7 clears
        wr_reg(8'h18, 32'h3);
        rd_const(8'h18, 0, "R7 unf clear");
        wr_reg(8'h0C, 32'h1);
        rd_const(8'h04, 0, "R7 ris clear");
        // R5 fill and overflow
        for (int i = 0; i < 16; i++) fire(10'(12'h100 + i));
        rd_const(8'h4C, 32'h1033, "R5 full");
        fire(10'h3EE);
        rd_const(8'h4C, 32'h1033, "R5 ptrs kept");
        rd_const(8'h10, 32'h1, "R5 ovf");
        wr_reg(8'h10, 32'h1);
        // R10 push and pop on full FIFO
        cyc(0, 1, 8'h48, 0, 1, 10'h155, "R10 full read");
        rd_const(8'h4C, 32'h1044, "R10 stays full");
        rd_const(8'h10, 0, "R10 no ovf");
        // R11 drain with wrap
        for (int i = 0; i < 16; i++) rd_reg(8'h48, "R11 drain");
        rd_const(8'h4C, 32'h144, "R11 wrapped");
        // R10 push and pop on empty FIFO
        cyc(0, 1, 8'h48, 0, 1, 10'h0AA, "R10 empty read");
        rd_const(8'h18, 32'h1, "R10 underflow");
        rd_const(8'h48, 32'h0AA, "R10 stored");
        // R7 set wins over clear
        cyc(1, 0, 8'h0C, 32'h1, 1, 10'h011, "R7 set wins");
        rd_const(8'h04, 32'h1, "R7 raw kept");
        wr_reg(8'h08, 32'h0);
        rd_const(8'h0C, 0, "R8 masked isc");
        repeat (3) @(negedge clk);
        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule